// File: doc/BRIEF.md
# Masked-Update Temperature Result Register

This block keeps the most recent temperature conversion result in a 16-bit read-only word. When the converter raises its done strobe, the block takes the new 12-bit two's complement sample and left-justifies it so that the sign lands in bit 15. It then clears every bit below the precision chosen by a 2-bit resolution code, and stores the result. The word is read one byte at a time through a byte-select mux that a serial bus slave drives.

While the bus slave reports that a read is in progress, a conversion that completes is not written into the held word. It is dropped, not queued, so a host that fetches the two bytes in turn never gets halves from different samples. Every sample still goes out, one cycle later, on a separate alarm tap so that fault evaluation never misses a conversion.

Top module: `temp_result_reg`

## Requirements
- R1: After reset the held word is zero, so both bytes read 0x00, and `alarm_valid` is low.
- R2: A cycle with `conv_done` high and `rd_busy` low loads the held word at that clock edge. The new value is visible on `rd_data` from the next cycle on.
- R3: A cycle with `conv_done` high and `rd_busy` high leaves the held word unchanged. The sample is lost, and the word changes again only at a later `conv_done` that sees `rd_busy` low.
- R4: The sample's bit 11 (sign) goes to word bit 15 and sample bit 0 goes to word bit 4. The resolution code keeps the top 9 (code 00), 10 (01), 11 (10) or 12 (11) bits of the word, and all lower bits read as zero.
- R5: A change of `res_sel` with no load leaves the held word as it was. Only later loads use the new code.
- R6: With `byte_sel` = 0, `rd_data` shows word bits 15:8 (the first byte of a read). With `byte_sel` = 1, it shows bits 7:0.
- R7: `alarm_valid` is high for exactly the cycle after each `conv_done`, whatever `rd_busy` is. In that cycle `alarm_temp` holds that sample, aligned and masked as in R4 with the code that was present at the strobe.
- R8: In a cycle with `conv_done` low the held word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion sample is present |
| conv_sample | input | 12 | Two's complement conversion result |
| res_sel | input | 2 | Resolution code: 00=9, 01=10, 10=11, 11=12 bits |
| rd_busy | input | 1 | High while the bus slave is reading the word |
| byte_sel | input | 1 | 0 selects the high byte, 1 the low byte |
| rd_data | output | 8 | Selected byte of the held word |
| alarm_valid | output | 1 | Pulses one cycle after every conversion strobe |
| alarm_temp | output | 16 | Aligned, masked sample for the fault evaluator |

## Verification
Directed cases load the extreme samples 0x7FF, 0x800 and 0xFFF at each resolution code. This separates a correct mask from off-by-one masks and confirms that the sign reaches bit 15. Strobes that arrive while a read is active are followed by idle cycles, which shows a dropped sample apart from one that was queued and applied late. A resolution change with no strobe in between shows a mask applied at load time apart from one applied at readout. Random traffic with busy about a third of the time then mixes these cases, and both bytes and the alarm tap are compared each cycle.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int TSR_SAMPLE_W = 12;
  localparam int TSR_WORD_W   = 16;
  localparam int TSR_RES_W    = 2;
  localparam int TSR_MIN_BITS = 9;
endpackage

// File: rtl/tsr_trunc.sv
module tsr_trunc #(
  parameter int SAMPLE_W = tsr_pkg::TSR_SAMPLE_W,
  parameter int WORD_W   = tsr_pkg::TSR_WORD_W,
  parameter int RES_W    = tsr_pkg::TSR_RES_W,
  parameter int MIN_BITS = tsr_pkg::TSR_MIN_BITS
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [RES_W-1:0]    res_code,
  output logic [WORD_W-1:0]   word
);
  localparam int PAD = WORD_W - SAMPLE_W;

  // Bits at or above WORD_W - kept survive; kept = MIN_BITS + code.
  function automatic logic [WORD_W-1:0] keep_mask(input logic [RES_W-1:0] code);
    int kept;
    logic [WORD_W-1:0] m;
    kept = MIN_BITS + int'(code);
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = (i >= WORD_W - kept);
    end
    return m;
  endfunction

  logic [WORD_W-1:0] aligned;
  assign aligned = {sample, {PAD{1'b0}}};
  assign word    = aligned & keep_mask(res_code);
endmodule

// File: rtl/tsr_hold.sv
module tsr_hold #(
  parameter int WORD_W = tsr_pkg::TSR_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              rd_busy,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] hold_q,
  output logic              load_en
);
  assign load_en = conv_done & ~rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_en) hold_q <= load_word;
  end

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !rd_busy) |=> (hold_q == $past(load_word)));
  // R3
  busy_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(hold_q));
  // R8
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(hold_q));
endmodule

// File: rtl/tsr_alarm_tap.sv
module tsr_alarm_tap #(
  parameter int WORD_W = tsr_pkg::TSR_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] sample_word,
  output logic              tap_valid,
  output logic [WORD_W-1:0] tap_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_valid <= 1'b0;
      tap_word  <= '0;
    end else begin
      tap_valid <= conv_done;
      if (conv_done) tap_word <= sample_word;
    end
  end

  // R7
  tap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> tap_valid);
  // R7
  tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !tap_valid);
endmodule

// File: rtl/tsr_byte_mux.sv
module tsr_byte_mux #(
  parameter int WORD_W = tsr_pkg::TSR_WORD_W
) (
  input  logic [WORD_W-1:0]                 word,
  input  logic [$clog2(WORD_W/8)-1:0]       byte_sel,
  output logic [7:0]                        byte_out
);
  localparam int NBYTES = WORD_W / 8;
  localparam int SEL_W  = $clog2(NBYTES);

  logic [7:0] lanes [NBYTES];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_lane
      assign lanes[g] = word[8*g +: 8];
    end
  endgenerate

  // Select 0 is the most significant byte.
  always_comb begin
    byte_out = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (SEL_W'(k) == byte_sel) byte_out = lanes[NBYTES-1-k];
    end
  end
endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg #(
  parameter int SAMPLE_W = tsr_pkg::TSR_SAMPLE_W,
  parameter int WORD_W   = tsr_pkg::TSR_WORD_W,
  parameter int RES_W    = tsr_pkg::TSR_RES_W,
  parameter int MIN_BITS = tsr_pkg::TSR_MIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic [RES_W-1:0]    res_sel,
  input  logic                rd_busy,
  input  logic                byte_sel,
  output logic [7:0]          rd_data,
  output logic                alarm_valid,
  output logic [WORD_W-1:0]   alarm_temp
);
  localparam int PAD = WORD_W - SAMPLE_W;

  logic [WORD_W-1:0] masked_word;
  logic [WORD_W-1:0] held_word;
  logic              load_en;

  tsr_trunc #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .RES_W(RES_W), .MIN_BITS(MIN_BITS))
    u_trunc (.sample(conv_sample), .res_code(res_sel), .word(masked_word));

  tsr_hold #(.WORD_W(WORD_W))
    u_hold (.clk(clk), .rst_n(rst_n), .conv_done(conv_done), .rd_busy(rd_busy),
            .load_word(masked_word), .hold_q(held_word), .load_en(load_en));

  tsr_alarm_tap #(.WORD_W(WORD_W))
    u_tap (.clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sample_word(masked_word),
           .tap_valid(alarm_valid), .tap_word(alarm_temp));

  tsr_byte_mux #(.WORD_W(WORD_W))
    u_mux (.word(held_word), .byte_sel(byte_sel), .byte_out(rd_data));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (held_word[PAD-1:0] == '0));
  // R4
  sign_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (held_word[WORD_W-1] == $past(conv_sample[SAMPLE_W-1])));
  // R5
  res_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && (res_sel != $past(res_sel))) |=> $stable(held_word));
endmodule

// File: tb/test_temp_result_reg.sv
`timescale 1ns/1ps
module test_temp_result_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_sample = '0;
  logic [1:0]  res_sel = '0;
  logic        rd_busy = 1'b0;
  logic        byte_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        alarm_valid;
  logic [15:0] alarm_temp;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] exp_word = '0;
  logic        exp_av = 1'b0;
  logic [15:0] exp_at = '0;

  always #2.5 clk = ~clk;

  temp_result_reg i_temp_result_reg (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_sample(conv_sample),
    .res_sel(res_sel), .rd_busy(rd_busy), .byte_sel(byte_sel),
    .rd_data(rd_data), .alarm_valid(alarm_valid), .alarm_temp(alarm_temp));

  // Expected word: shift left by 4, then clear (7 - code) bits from the bottom.
  function automatic logic [15:0] bench_trunc(logic [11:0] s, logic [1:0] code);
    logic [15:0] w;
    int drop;
    w = 16'(s) << 4;
    drop = 7 - int'(code);
    return (w >> drop) << drop;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    byte_sel = 1'b0; #0.5;
    check({8'h00, rd_data}, {8'h00, exp_word[15:8]}, {tag, " R6 high byte"});
    byte_sel = 1'b1; #0.5;
    check({8'h00, rd_data}, {8'h00, exp_word[7:0]}, {tag, " R6 low byte"});
    check({15'h0, alarm_valid}, {15'h0, exp_av}, {tag, " R7 alarm_valid"});
    if (exp_av) check(alarm_temp, exp_at, {tag, " R7 alarm_temp"});
  endtask

  task automatic step(input logic cd, input logic [11:0] s, input logic [1:0] r,
                      input logic busy, input string tag);
    @(negedge clk);
    conv_done = cd; conv_sample = s; res_sel = r; rd_busy = busy;
    @(posedge clk);
    exp_av = cd;
    if (cd) exp_at = bench_trunc(s, r);
    if (cd && !busy) exp_word = bench_trunc(s, r);
    #1;
    check_all(tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    step(1'b0, 12'h000, 2'b00, 1'b0, "R1 idle after reset");

    // R4: extremes at every resolution
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 12'h7FF, 2'(c), 1'b0, "R2 R4 max positive");
      step(1'b1, 12'h800, 2'(c), 1'b0, "R4 most negative");
      step(1'b1, 12'hFFF, 2'(c), 1'b0, "R4 minus one lsb");
    end

    // R3: dropped sample is not applied later
    step(1'b1, 12'h123, 2'b11, 1'b0, "R2 load before read");
    step(1'b1, 12'hABC, 2'b11, 1'b1, "R3 strobe during read");
    step(1'b0, 12'hABC, 2'b11, 1'b0, "R3 R8 no late load");
    step(1'b0, 12'h000, 2'b11, 1'b1, "R8 busy without strobe");
    step(1'b1, 12'h456, 2'b11, 1'b0, "R2 next free strobe loads");

    // R5: resolution change alone keeps the held value
    step(1'b1, 12'h7FF, 2'b11, 1'b0, "R4 full load");
    step(1'b0, 12'h000, 2'b00, 1'b0, "R5 res to 9 bits");
    step(1'b0, 12'h000, 2'b01, 1'b0, "R5 res to 10 bits");
    step(1'b1, 12'h7FF, 2'b00, 1'b0, "R5 new code on next load");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, 12'($urandom), 2'($urandom), ($urandom % 3) == 0,
           "R2/R3/R4/R7/R8 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule